// File: doc/BRIEF.md
# Hybrid-Way MRU-Swap Cache Controller

This block runs the data path of a set-associative L1 data cache in its high-performance mode. Each set has one line in a fast bank and several lines in slower banks whose reads are destructive. The fast line of a set always holds that set's most recently used line. One tag and control array holds tags, valid bits, dirty bits and the recency order of the slow ways. It is separate from the data banks. All tags of a set are compared in the lookup cycle while the fast bank is read. A hit in the fast way is answered at once and no slow bank is touched.

A hit in a slow way costs two more cycles to read the slow bank. After the data is returned, the hit line moves into the fast way and the line that was in the fast way goes into the slot the hit line left. The fast bank and that slow bank are locked for the whole sequence. On a miss the controller sends one refill request to the next level and holds it until the data arrives. The refilled line goes into the fast way. The old fast line moves into the least recently used slow way, and the line already there is evicted. A dirty evicted line is sent to the next level as a writeback pulse.

Each line holds one data word. Requests use a valid/ready handshake, and the controller serves one request at a time.

Top module: `hybrid_mru_cache`

## Requirements
- R1: After reset every line is invalid and req_ready is high. rsp_valid, fill_req_valid, wb_valid and every bit of bank_busy are low.
- R2: A request that hits the fast way gives rsp_valid for one cycle in the second cycle after the acceptance edge, with rsp_hit high and the line's word. bank_busy stays zero.
- R3: A request that hits a slow way gives rsp_valid for one cycle in the fourth cycle after the acceptance edge, with rsp_hit high and the line's word.
- R4: After a slow-way hit, the hit line sits in the fast way. The line that was in the fast way sits in the slow way that held the hit line.
- R5: A slow-way hit sets bank_busy for cycles 2, 3 and 4 after acceptance. Exactly two bits are set: bit 0, which is the fast bank, and bit 1+w, where w is the slow way that hit (slow ways are numbered from 0).
- R6: On a miss, fill_req_valid rises in cycle 2 with fill_req_addr equal to the request address. It holds steady until fill_rsp_valid is sampled. The response follows in the next cycle with rsp_hit low.
- R7: A miss places the refilled line in the fast way. If the fast way was valid, its old line moves into the least recently used slow way and replaces the line there.
- R8: If the replaced slow line is valid and dirty, wb_valid pulses for one cycle in cycle 2 with that line's address and word. Otherwise wb_valid stays low.
- R9: The recency order covers only the slow ways, and a slow way becomes most recent when a line is moved into it. After reset, slow way 0 is most recent and the highest-numbered slow way is least recent.
- R10: A write hit stores req_wdata and marks the line dirty. A write miss allocates the line with req_wdata and marks it dirty. For a write, rsp_rdata returns the written word.
- R11: req_ready is low from the acceptance edge until the request finishes, so only one request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; the low IDX_W bits select the set |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response was a hit |
| rsp_rdata | output | DATA_W | Line word (written word on writes) |
| fill_req_valid | output | 1 | Refill request, held until answered |
| fill_req_addr | output | ADDR_W | Refill address |
| fill_rsp_valid | input | 1 | Refill data present |
| fill_rsp_data | input | DATA_W | Refill word |
| wb_valid | output | 1 | Writeback strobe |
| wb_addr | output | ADDR_W | Writeback address |
| wb_data | output | DATA_W | Writeback word |
| bank_busy | output | SLOW_WAYS+1 | Bank locks: bit 0 is the fast bank, bit 1+w is slow way w |

## Verification
The in-line assertions check these rules on every cycle:
- bank_busy is either zero or exactly the fast bank plus one slow bank, and it never overlaps req_ready.
- A refill request stays stable until it is answered.
- Writeback and response strobes last a single cycle.
- Response timing after the lookup and after the slow read matches the hit latencies.

Only the bench scenarios can show where lines end up. This covers the swap that makes a former fast line hit in the vacated slow slot, the choice of the LRU slow way, that a dirty line written back returns with its written word on a later refill, and the exact data on every response. These are checked against a behavioural model that keeps the slow-way order as a list per set.

// File: rtl/hybrid_mru_cache.sv
module hybrid_mru_cache #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int SETS      = 4,
  parameter int SLOW_WAYS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 fill_req_valid,
  output logic [ADDR_W-1:0]    fill_req_addr,
  input  logic                 fill_rsp_valid,
  input  logic [DATA_W-1:0]    fill_rsp_data,
  output logic                 wb_valid,
  output logic [ADDR_W-1:0]    wb_addr,
  output logic [DATA_W-1:0]    wb_data,
  output logic [SLOW_WAYS:0]   bank_busy
);

  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SW_W  = (SLOW_WAYS > 1) ? $clog2(SLOW_WAYS) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_SRD1, ST_SRD2, ST_SWAP, ST_FILL} state_t;

  state_t state;

  logic [TAG_W-1:0]     f_tag  [SETS];
  logic [DATA_W-1:0]    f_data [SETS];
  logic [SETS-1:0]      f_val, f_dirty;
  logic [TAG_W-1:0]     s_tag  [SETS][SLOW_WAYS];
  logic [DATA_W-1:0]    s_data [SETS][SLOW_WAYS];
  logic [SW_W-1:0]      s_rank [SETS][SLOW_WAYS];
  logic [SLOW_WAYS-1:0] s_val  [SETS];
  logic [SLOW_WAYS-1:0] s_dirty[SETS];

  logic                 r_write, r_evict;
  logic [TAG_W-1:0]     r_tag;
  logic [IDX_W-1:0]     r_idx;
  logic [DATA_W-1:0]    r_wdata, rd_buf;
  logic [SW_W-1:0]      r_way;

  logic                 fast_hit;
  logic [SLOW_WAYS-1:0] slow_match;
  logic [SW_W-1:0]      hit_way, victim;
  logic                 lock;
  logic [DATA_W-1:0]    fill_word, slow_word;

  assign req_ready      = (state == ST_IDLE);
  assign fill_req_valid = (state == ST_FILL);
  assign fill_req_addr  = {r_tag, r_idx};
  assign fast_hit       = f_val[r_idx] && (f_tag[r_idx] == r_tag);
  assign lock           = (state == ST_SRD1) || (state == ST_SRD2) || (state == ST_SWAP);
  assign fill_word      = r_write ? r_wdata : fill_rsp_data;
  assign slow_word      = r_write ? r_wdata : rd_buf;

  for (genvar g = 0; g < SLOW_WAYS; g++) begin : g_cmp
    assign slow_match[g] = s_val[r_idx][g] && (s_tag[r_idx][g] == r_tag);
    assign bank_busy[g+1] = lock && (r_way == SW_W'(g));
  end
  assign bank_busy[0] = lock;

  always_comb begin
    hit_way = '0;
    victim  = '0;
    for (int j = 0; j < SLOW_WAYS; j++) begin
      if (slow_match[j]) hit_way = SW_W'(j);
      if (s_rank[r_idx][j] == SW_W'(SLOW_WAYS-1)) victim = SW_W'(j);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
      r_write   <= 1'b0;
      r_evict   <= 1'b0;
      r_tag     <= '0;
      r_idx     <= '0;
      r_wdata   <= '0;
      r_way     <= '0;
      rd_buf    <= '0;
      f_val     <= '0;
      f_dirty   <= '0;
      for (int i = 0; i < SETS; i++) begin
        f_tag[i]   <= '0;
        f_data[i]  <= '0;
        s_val[i]   <= '0;
        s_dirty[i] <= '0;
        for (int j = 0; j < SLOW_WAYS; j++) begin
          s_tag[i][j]  <= '0;
          s_data[i][j] <= '0;
          s_rank[i][j] <= SW_W'(j);
        end
      end
    end else begin
      rsp_valid <= 1'b0;
      wb_valid  <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          r_write <= req_write;
          r_tag   <= req_addr[ADDR_W-1:IDX_W];
          r_idx   <= req_addr[IDX_W-1:0];
          r_wdata <= req_wdata;
          state   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (fast_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_rdata <= r_write ? r_wdata : f_data[r_idx];
            if (r_write) begin
              f_data[r_idx]  <= r_wdata;
              f_dirty[r_idx] <= 1'b1;
            end
            state <= ST_IDLE;
          end else if (|slow_match) begin
            r_way <= hit_way;
            state <= ST_SRD1;
          end else begin
            r_way   <= victim;
            r_evict <= f_val[r_idx];
            if (f_val[r_idx] && s_val[r_idx][victim] && s_dirty[r_idx][victim]) begin
              wb_valid <= 1'b1;
              wb_addr  <= {s_tag[r_idx][victim], r_idx};
              wb_data  <= s_data[r_idx][victim];
            end
            state <= ST_FILL;
          end
        end
        ST_SRD1: begin
          rd_buf                <= s_data[r_idx][r_way];
          s_data[r_idx][r_way]  <= '0;
          state                 <= ST_SRD2;
        end
        ST_SRD2: begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_rdata <= slow_word;
          state     <= ST_SWAP;
        end
        ST_SWAP: begin
          f_tag[r_idx]          <= r_tag;
          f_data[r_idx]         <= slow_word;
          f_dirty[r_idx]        <= s_dirty[r_idx][r_way] | r_write;
          s_tag[r_idx][r_way]   <= f_tag[r_idx];
          s_data[r_idx][r_way]  <= f_data[r_idx];
          s_dirty[r_idx][r_way] <= f_dirty[r_idx];
          s_val[r_idx][r_way]   <= f_val[r_idx];
          for (int j = 0; j < SLOW_WAYS; j++) begin
            if (SW_W'(j) == r_way) s_rank[r_idx][j] <= '0;
            else if (s_rank[r_idx][j] < s_rank[r_idx][r_way]) s_rank[r_idx][j] <= s_rank[r_idx][j] + 1'b1;
          end
          state <= ST_IDLE;
        end
        ST_FILL: if (fill_rsp_valid) begin
          f_tag[r_idx]   <= r_tag;
          f_data[r_idx]  <= fill_word;
          f_dirty[r_idx] <= r_write;
          f_val[r_idx]   <= 1'b1;
          if (r_evict) begin
            s_tag[r_idx][r_way]   <= f_tag[r_idx];
            s_data[r_idx][r_way]  <= f_data[r_idx];
            s_dirty[r_idx][r_way] <= f_dirty[r_idx];
            s_val[r_idx][r_way]   <= 1'b1;
            for (int j = 0; j < SLOW_WAYS; j++) begin
              if (SW_W'(j) == r_way) s_rank[r_idx][j] <= '0;
              else if (s_rank[r_idx][j] < s_rank[r_idx][r_way]) s_rank[r_idx][j] <= s_rank[r_idx][j] + 1'b1;
            end
          end
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_rdata <= fill_word;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_lock_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_busy != '0) |-> (bank_busy[0] && $countones(bank_busy) == 2));

  p_lock_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_busy != '0) |-> !req_ready);

  p_fast_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOK && fast_hit) |=> (rsp_valid && rsp_hit && req_ready && bank_busy == '0));

  p_slow_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SRD2) |=> (rsp_valid && rsp_hit && bank_busy[0]));

  p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_rsp_valid) |=> (fill_req_valid && $stable(fill_req_addr)));

  p_fill_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && fill_rsp_valid) |=> (rsp_valid && !rsp_hit && req_ready));

  p_wb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  p_wb_with_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> fill_req_valid);

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/hybrid_mru_cache_tb_top.sv
module hybrid_mru_cache_tb_top;
  localparam int AW = 12, DW = 32, NS = 4, NW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic fill_rsp_valid = 1'b0;
  logic [DW-1:0] fill_rsp_data = '0;
  logic req_ready, rsp_valid, rsp_hit, fill_req_valid, wb_valid;
  logic [DW-1:0] rsp_rdata, wb_data;
  logic [AW-1:0] fill_req_addr, wb_addr;
  logic [NW:0] bank_busy;

  always #2 clk = ~clk;

  hybrid_mru_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .SLOW_WAYS(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .bank_busy(bank_busy));

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: per-set fast line, slow slots, recency list (front = most recent)
  logic [9:0]  m_ftag[NS];
  logic [31:0] m_fdata[NS];
  bit          m_fval[NS], m_fdirty[NS];
  logic [9:0]  m_stag[NS][NW];
  logic [31:0] m_sdata[NS][NW];
  bit          m_sval[NS][NW], m_sdirty[NS][NW];
  int          order[NS][$];
  logic [31:0] nl_mem [int];

  typedef enum int {K_FAST, K_SLOW, K_MISS} kind_t;
  kind_t last_kind;
  int    last_way;

  function automatic logic [31:0] nl_read(input logic [AW-1:0] a);
    if (nl_mem.exists(int'(a))) return nl_mem[int'(a)];
    return 32'h5EED_0000 ^ {20'h0, a};
  endfunction

  task automatic touch(input int s, input int w);
    for (int k = 0; k < order[s].size(); k++)
      if (order[s][k] == w) begin order[s].delete(k); break; end
    order[s].push_front(w);
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [31:0] wd, input int dly);
    int s, sw, vic;
    logic [9:0] tg;
    logic [31:0] exp_d, nd;
    bit exp_wb, nd_dirty;
    kind_t k;
    logic [9:0] otag; logic [31:0] odata; bit odirty, oval;
    s = int'(addr[1:0]); tg = addr[11:2]; sw = -1;
    for (int j = 0; j < NW; j++) if (m_sval[s][j] && m_stag[s][j] == tg) sw = j;
    if (m_fval[s] && m_ftag[s] == tg) k = K_FAST;
    else if (sw >= 0) k = K_SLOW;
    else k = K_MISS;
    vic = order[s][$];
    exp_wb = (k == K_MISS) && m_fval[s] && m_sval[s][vic] && m_sdirty[s][vic];

    @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready before request", {31'b0, req_ready}, 1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0 && rsp_valid == 1'b0, "R11", "busy in cycle 1",
          {30'b0, req_ready, rsp_valid}, 0);

    otag = m_ftag[s]; odata = m_fdata[s]; odirty = m_fdirty[s]; oval = m_fval[s];
    if (k == K_FAST) begin
      exp_d = wr ? wd : m_fdata[s];
      @(negedge clk);
      check(rsp_valid && rsp_hit, "R2", "fast hit strobe", {30'b0, rsp_valid, rsp_hit}, 3);
      check(rsp_rdata == exp_d, wr ? "R10" : "R2", "fast hit data", rsp_rdata, exp_d);
      check(bank_busy == '0, "R2", "no lock on fast hit", {28'b0, bank_busy}, 0);
      if (wr) begin m_fdata[s] = wd; m_fdirty[s] = 1'b1; end
    end else if (k == K_SLOW) begin
      exp_d = wr ? wd : m_sdata[s][sw];
      for (int c = 2; c <= 4; c++) begin
        @(negedge clk);
        check(bank_busy == NW'(1) + (NW+1)'(1 << (sw + 1)), "R5", "bank lock pair",
              {28'b0, bank_busy}, 1 + (1 << (sw + 1)));
        check(rsp_valid == (c == 4), "R3", "slow hit strobe timing", {31'b0, rsp_valid}, (c == 4));
      end
      check(rsp_hit && rsp_rdata == exp_d, wr ? "R10" : "R3", "slow hit data", rsp_rdata, exp_d);
      @(negedge clk);
      check(bank_busy == '0 && req_ready, "R5", "lock released", {28'b0, bank_busy}, 0);
      m_ftag[s] = tg; m_fdata[s] = exp_d; m_fdirty[s] = m_sdirty[s][sw] | wr;
      m_stag[s][sw] = otag; m_sdata[s][sw] = odata; m_sdirty[s][sw] = odirty; m_sval[s][sw] = oval;
      touch(s, sw);
    end else begin
      @(negedge clk);
      check(fill_req_valid && fill_req_addr == addr, "R6", "refill request",
            {20'b0, fill_req_addr}, {20'b0, addr});
      check(wb_valid == exp_wb, "R8", "writeback strobe", {31'b0, wb_valid}, {31'b0, exp_wb});
      if (exp_wb) begin
        check(wb_addr == {m_stag[s][vic], addr[1:0]}, "R8", "writeback address",
              {20'b0, wb_addr}, {20'b0, m_stag[s][vic], addr[1:0]});
        check(wb_data == m_sdata[s][vic], "R8", "writeback data", wb_data, m_sdata[s][vic]);
        nl_mem[int'({m_stag[s][vic], addr[1:0]})] = m_sdata[s][vic];
      end
      for (int c = 0; c < dly; c++) begin
        @(negedge clk);
        check(fill_req_valid && !rsp_valid, "R6", "refill held", {31'b0, fill_req_valid}, 1);
      end
      nd = wr ? wd : nl_read(addr);
      nd_dirty = wr;
      fill_rsp_valid = 1'b1; fill_rsp_data = nl_read(addr);
      @(negedge clk);
      fill_rsp_valid = 1'b0;
      check(rsp_valid && !rsp_hit, "R6", "miss response", {30'b0, rsp_valid, rsp_hit}, 2);
      check(rsp_rdata == nd, wr ? "R10" : "R6", "miss data", rsp_rdata, nd);
      if (oval) begin
        m_stag[s][vic] = otag; m_sdata[s][vic] = odata; m_sdirty[s][vic] = odirty; m_sval[s][vic] = 1'b1;
        touch(s, vic);
      end
      m_ftag[s] = tg; m_fdata[s] = nd; m_fdirty[s] = nd_dirty; m_fval[s] = 1'b1;
      sw = vic;
    end
    last_kind = k; last_way = sw;
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_fval[s] = 0; m_fdirty[s] = 0; m_ftag[s] = '0; m_fdata[s] = '0;
      for (int j = 0; j < NW; j++) begin
        m_sval[s][j] = 0; m_sdirty[s][j] = 0; m_stag[s][j] = '0; m_sdata[s][j] = '0;
        order[s].push_back(j);
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready after reset", {31'b0, req_ready}, 1);
    check(!rsp_valid && !fill_req_valid && !wb_valid, "R1", "strobes idle after reset",
          {29'b0, rsp_valid, fill_req_valid, wb_valid}, 0);
    check(bank_busy == '0, "R1", "no locks after reset", {28'b0, bank_busy}, 0);

    access(0, 12'h004, 0, 1);
    check(last_kind == K_MISS, "R1", "first access misses", last_kind, K_MISS);
    access(0, 12'h004, 0, 0);
    check(last_kind == K_FAST, "R2", "refilled line in fast way", last_kind, K_FAST);
    access(0, 12'h008, 0, 2);
    access(0, 12'h004, 0, 0);
    check(last_kind == K_SLOW && last_way == NW-1, "R9", "old fast line went to last slow way",
          last_way, NW-1);
    access(0, 12'h004, 0, 0);
    check(last_kind == K_FAST, "R4", "hit line now in fast way", last_kind, K_FAST);
    access(0, 12'h008, 0, 0);
    check(last_kind == K_SLOW && last_way == NW-1, "R4", "former fast line in vacated slot",
          last_way, NW-1);
    access(1, 12'h008, 32'h0000_1234, 0);
    access(0, 12'h008, 0, 0);
    check(rsp_rdata == 32'h0000_1234, "R10", "write hit stored", rsp_rdata, 32'h0000_1234);
    access(0, 12'h00C, 0, 0);
    check(last_way == 1, "R7", "victim is least recent slow way", last_way, 1);
    access(0, 12'h010, 0, 1);
    access(0, 12'h014, 0, 0);
    access(0, 12'h018, 0, 0);
    access(0, 12'h008, 0, 1);
    check(rsp_rdata == 32'h0000_1234, "R8", "written-back word returns on refill",
          rsp_rdata, 32'h0000_1234);
    access(1, 12'h01C, 32'hCAFE_F00D, 0);
    check(last_kind == K_MISS, "R10", "write miss allocates", last_kind, K_MISS);
    access(0, 12'h01C, 0, 0);
    check(last_kind == K_FAST && rsp_rdata == 32'hCAFE_F00D, "R10", "write miss data kept",
          rsp_rdata, 32'hCAFE_F00D);

    begin
      int unsigned lcg = 32'h1357_9BDF;
      for (int n = 0; n < 400; n++) begin
        logic [AW-1:0] a;
        lcg = lcg * 1103515245 + 12345;
        a = {7'b0, lcg[18:16], lcg[21:20]};
        access(lcg[25:24] == 2'b00, a, lcg ^ 32'hA5A5_0000, int'(lcg[28:27]) % 3);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule